// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block sits between a set of interrupt request sources and a processor's IRQ line. Sixteen vector slots each bind one source number to a handler address. The slot number sets the priority, and slot 0 is the most urgent. A seventeenth, default address serves any request that no enabled slot claims. The block tracks the priority level of the handler now running, so the IRQ line is raised only for sources that belong to slots more urgent than that level. Levels are kept on a small stack, which lets handlers nest.

Software drives the block through a simple register port with read and write strobes. Reading the vector register acknowledges the most urgent pending request. The read returns that request's handler address and moves the block to its level. Writing the vector register, with any data, marks the end of the handler and returns to the level that was active before. The block takes two request vectors: a raw one, used when searching at acknowledge, and a masked one, used to gate the IRQ line.

Top module: `vic_prio_ctrl`

## Requirements
- R1: After reset, the level is idle (17). Every slot address, slot control value and the default address read as zero. The IRQ output follows any set bit of the masked request vector.
- R2: A slot control value has its enable in bit 5 and its source number in bits 4:0. Control values read back at byte offset 0x200+4*slot and handler addresses at 0x100+4*slot. The default address is read and written at 0x034.
- R3: The IRQ output is high exactly when a masked request bit matches the source of an enabled slot numbered strictly below the current level. At idle, any masked request bit raises it. At level 16, any enabled slot's source raises it.
- R4: A read of the vector register (0x030) finds the smallest level i below the current level such that a raw request matches an enabled slot numbered below i+1 (for i = 16, any raw bit). If one exists, the read returns the address for level i, saves the current level as the return level of i, and moves to level i. Level 16 returns the default address.
- R5: A vector read with no such level returns the address of the current level and leaves the level unchanged. At idle, it returns the default address.
- R6: A write to the vector register ignores its data. Below idle, it restores the level saved at the matching acknowledge, so nested handlers unwind in order. At idle, it has no effect.
- R7: The eight identification bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 read, in that order, at byte offsets 0xFE0 to 0xFFC.
- R8: A change to a slot control value changes the IRQ gating from the cycle after the write.
- R9: The level changes only on a strobe cycle that reads or writes the vector register. Each strobe cycle acts once. Other and unmapped offsets never move the level, unmapped offsets read zero, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the read strobe cycle |
| src_raw | input | 32 | Raw request vector, used by the acknowledge search |
| src_masked | input | 32 | Masked request vector, gates the IRQ line |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted level or return stack shows up at the very next vector read as a wrong handler address. Before that, it appears as an IRQ line that rises or stays quiet for the wrong sources in the cycle after the state diverges. Wrong priority masks appear at the IRQ output one cycle after the control write that caused them. A lost or doubled acknowledge surfaces at the following end-of-handler write, because that write unwinds to the wrong level.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned SLOT_ADDR_WORD = 'h040;
  localparam int unsigned SLOT_CTRL_WORD = 'h080;
  localparam int unsigned VECT_WORD      = 12;
  localparam int unsigned DEFAULT_WORD   = 13;
  localparam int unsigned ID_WORD        = 'h3F8;
  localparam int unsigned ID_COUNT       = 8;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h90;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/vic_rst_sync.sv
module vic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile #(
  parameter int NSLOT  = 16,
  parameter int DATA_W = 32,
  parameter int WORD_W = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [WORD_W-1:0]              word,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NSLOT:0][DATA_W-1:0]     vaddr,
  output logic [NSLOT-1:0][7:0]          vctrl
);
  import vic_pkg::*;

  logic [NSLOT:0][DATA_W-1:0] vaddr_d;
  logic [NSLOT-1:0][7:0]      vctrl_d;

  always_comb begin
    vaddr_d = vaddr;
    vctrl_d = vctrl;
    if (wr_en) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (int'(word) == int'(SLOT_ADDR_WORD) + s) vaddr_d[s] = wdata;
        if (int'(word) == int'(SLOT_CTRL_WORD) + s) vctrl_d[s] = wdata[7:0];
      end
      if (int'(word) == int'(DEFAULT_WORD)) vaddr_d[NSLOT] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr <= '0;
      vctrl <= '0;
    end else if (wr_en) begin
      vaddr <= vaddr_d;
      vctrl <= vctrl_d;
    end
  end
endmodule

// File: rtl/vic_mask_gen.sv
module vic_mask_gen #(
  parameter int NSLOT = 16,
  parameter int SRC_W = 32,
  parameter int CTL_W = 6
) (
  input  logic [NSLOT-1:0][CTL_W-1:0] ctl,
  output logic [NSLOT+1:0][SRC_W-1:0] masks
);
  localparam int IDX_W = CTL_W - 1;

  assign masks[0] = '0;
  for (genvar s = 0; s < NSLOT; s++) begin : g_acc
    logic [SRC_W-1:0] slot_bit;
    assign slot_bit = ctl[s][IDX_W] ?
                      ({{(SRC_W-1){1'b0}}, 1'b1} << ctl[s][IDX_W-1:0]) : '0;
    assign masks[s+1] = masks[s] | slot_bit;
  end
  assign masks[NSLOT+1] = '1;
endmodule

// File: rtl/vic_level_search.sv
module vic_level_search #(
  parameter int NSLOT = 16,
  parameter int SRC_W = 32,
  parameter int LVL_W = 5
) (
  input  logic [NSLOT+1:0][SRC_W-1:0] masks,
  input  logic [SRC_W-1:0]            raw,
  input  logic [LVL_W-1:0]            cur_lvl,
  output logic                        found,
  output logic [LVL_W-1:0]            hit_lvl
);
  logic [NSLOT:0] cand;

  for (genvar l = 0; l <= NSLOT; l++) begin : g_cand
    assign cand[l] = (|(raw & masks[l+1])) && (LVL_W'(l) < cur_lvl);
  end

  always_comb begin
    found   = 1'b0;
    hit_lvl = '0;
    for (int l = NSLOT; l >= 0; l--) begin
      if (cand[l]) begin
        found   = 1'b1;
        hit_lvl = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/vic_prio_ctrl.sv
module vic_prio_ctrl #(
  parameter int NSLOT  = 16,
  parameter int SRC_W  = 32,
  parameter int DATA_W = 32,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_W-1:0]  src_raw,
  input  logic [SRC_W-1:0]  src_masked,
  output logic              irq_o
);
  import vic_pkg::*;

  localparam int WORD_W   = AW - 2;
  localparam int LVL_W    = $clog2(NSLOT + 2);
  localparam int CTL_W    = $clog2(SRC_W) + 1;
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NSLOT + 1);
  localparam logic [LVL_W-1:0] LVL_DEF  = LVL_W'(NSLOT);

  logic                        rst_sync_n;
  logic [WORD_W-1:0]           word;
  logic                        aligned;
  logic                        rd_hit, wr_hit;
  logic                        ack, eoi;
  logic [NSLOT:0][DATA_W-1:0]  vaddr;
  logic [NSLOT-1:0][7:0]       vctrl;
  logic [NSLOT-1:0][CTL_W-1:0] ctl_used;
  logic [NSLOT+1:0][SRC_W-1:0] masks;
  logic                        found;
  logic [LVL_W-1:0]            hit_lvl;
  logic [LVL_W-1:0]            cur_lvl, cur_lvl_d;
  logic [NSLOT:0][LVL_W-1:0]   prev_lvl, prev_lvl_d;
  logic                        lvl_en;
  logic [LVL_W-1:0]            vec_lvl;
  logic [DATA_W-1:0]           vec_val;

  vic_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign word    = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign rd_hit  = bus_rd && aligned;
  assign wr_hit  = bus_wr && aligned;
  assign ack     = rd_hit && (int'(word) == int'(VECT_WORD));
  assign eoi     = wr_hit && (int'(word) == int'(VECT_WORD));

  vic_regfile #(.NSLOT(NSLOT), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_hit), .word(word),
    .wdata(bus_wdata), .vaddr(vaddr), .vctrl(vctrl)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_ctl
    assign ctl_used[s] = vctrl[s][CTL_W-1:0];
  end

  vic_mask_gen #(.NSLOT(NSLOT), .SRC_W(SRC_W), .CTL_W(CTL_W)) u_masks (
    .ctl(ctl_used), .masks(masks)
  );

  vic_level_search #(.NSLOT(NSLOT), .SRC_W(SRC_W), .LVL_W(LVL_W)) u_search (
    .masks(masks), .raw(src_raw), .cur_lvl(cur_lvl),
    .found(found), .hit_lvl(hit_lvl)
  );

  // level stack next state
  always_comb begin
    cur_lvl_d  = cur_lvl;
    prev_lvl_d = prev_lvl;
    if (ack && found) begin
      prev_lvl_d[hit_lvl] = cur_lvl;
      cur_lvl_d           = hit_lvl;
    end else if (eoi && (cur_lvl != LVL_IDLE)) begin
      cur_lvl_d = prev_lvl[cur_lvl];
    end
  end

  assign lvl_en = ack || eoi;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cur_lvl  <= LVL_IDLE;
      prev_lvl <= {(NSLOT+1){LVL_IDLE}};
    end else if (lvl_en) begin
      cur_lvl  <= cur_lvl_d;
      prev_lvl <= prev_lvl_d;
    end
  end

  // read path
  assign vec_lvl = found ? hit_lvl : cur_lvl;
  assign vec_val = (vec_lvl >= LVL_DEF) ? vaddr[NSLOT] : vaddr[vec_lvl];

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (int'(word) == int'(SLOT_ADDR_WORD) + s) bus_rdata = vaddr[s];
        if (int'(word) == int'(SLOT_CTRL_WORD) + s) bus_rdata = DATA_W'(vctrl[s]);
      end
      for (int b = 0; b < int'(ID_COUNT); b++) begin
        if (int'(word) == int'(ID_WORD) + b) bus_rdata = DATA_W'(id_byte(3'(b)));
      end
      if (int'(word) == int'(DEFAULT_WORD)) bus_rdata = vaddr[NSLOT];
      if (ack) bus_rdata = vec_val;
    end
  end

  assign irq_o = |(src_masked & masks[cur_lvl]);
endmodule

// File: rtl/vic_prio_chk.sv
module vic_prio_chk #(
  parameter int LVL_W = 5,
  parameter int NSLOT = 16,
  parameter int SRC_W = 32,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [SRC_W-1:0] src_masked,
  input logic             irq_o,
  input logic [LVL_W-1:0] cur_lvl
);
  logic vec_acc;
  assign vec_acc = (bus_rd || bus_wr) && (bus_addr == AW'('h030));

  // R9
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl <= LVL_W'(NSLOT + 1));

  // R3
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == LVL_W'(NSLOT + 1)) |-> (irq_o == (|src_masked)));

  // R3
  top_level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == '0) |-> !irq_o);

  // R4
  ack_no_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == AW'('h030)) |=> (cur_lvl <= $past(cur_lvl)));

  // R9
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_acc |=> $stable(cur_lvl));

  // R6
  idle_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == AW'('h030) && cur_lvl == LVL_W'(NSLOT + 1))
      |=> (cur_lvl == LVL_W'(NSLOT + 1)));
endmodule

bind vic_prio_ctrl vic_prio_chk #(.LVL_W(LVL_W), .NSLOT(NSLOT), .SRC_W(SRC_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .src_masked(src_masked), .irq_o(irq_o), .cur_lvl(cur_lvl)
);

// File: tb/tb_vic_prio_ctrl.sv
`timescale 1ns/1ps
module tb_vic_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_rd, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] src_raw, src_masked;
  logic        irq_o;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_addr [17];
  logic [7:0]  m_ctrl [16];
  int          m_cur;
  int          m_prev [17];

  always #2.5 clk = ~clk;

  vic_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_raw(src_raw), .src_masked(src_masked), .irq_o(irq_o)
  );

  function automatic logic [31:0] lvl_mask(int l);
    logic [31:0] m = '0;
    if (l >= 17) return 32'hFFFF_FFFF;
    for (int i = 0; i < l; i++)
      if (m_ctrl[i][5]) m |= 32'h1 << m_ctrl[i][4:0];
    return m;
  endfunction

  function automatic int search_lvl();
    for (int i = 0; i < m_cur; i++)
      if ((src_raw & lvl_mask(i + 1)) != 0) return i;
    return m_cur;
  endfunction

  function automatic logic [31:0] lvl_addr(int l);
    return (l >= 16) ? m_addr[16] : m_addr[l];
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    logic [7:0] ids [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a >= 12'h100 && a < 12'h140) return m_addr[(a - 12'h100) >> 2];
    if (a >= 12'h200 && a < 12'h240) return {24'h0, m_ctrl[(a - 12'h200) >> 2]};
    if (a >= 12'hFE0) return {24'h0, ids[(a - 12'hFE0) >> 2]};
    if (a == 12'h030) return lvl_addr(search_lvl());
    if (a == 12'h034) return m_addr[16];
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(string tag);
    check(tag, {31'h0, irq_o}, {31'h0, (src_masked & lvl_mask(m_cur)) != 0});
  endtask

  task automatic set_src(logic [31:0] raw, logic [31:0] msk);
    @(negedge clk);
    src_raw = raw; src_masked = msk;
    #1 chk_irq("R3 irq gating");
  endtask

  task automatic do_read(logic [11:0] a, string tag);
    logic [31:0] e;
    int nl;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    e = exp_read(a);
    #1 check(tag, bus_rdata, e);
    chk_irq("R3 irq before access");
    nl = search_lvl();
    @(posedge clk);
    if (a == 12'h030 && nl < m_cur) begin
      m_prev[nl] = m_cur; m_cur = nl;
    end
    #1 bus_rd = 1'b0;
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    if (a >= 12'h100 && a < 12'h140) m_addr[(a - 12'h100) >> 2] = d;
    else if (a >= 12'h200 && a < 12'h240) m_ctrl[(a - 12'h200) >> 2] = d[7:0];
    else if (a == 12'h034) m_addr[16] = d;
    else if (a == 12'h030 && m_cur < 17) m_cur = m_prev[m_cur];
    #1 bus_wr = 1'b0;
    #1 chk_irq("R8 irq after write");
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0190));
    for (int i = 0; i < 17; i++) begin m_addr[i] = '0; m_prev[i] = 17; end
    for (int i = 0; i < 16; i++) m_ctrl[i] = '0;
    m_cur = 17;
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    src_raw = '0; src_masked = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset contents and idle gating
    do_read(12'h100, "R1 slot0 addr");
    do_read(12'h13C, "R1 slot15 addr");
    do_read(12'h23C, "R1 slot15 ctrl");
    do_read(12'h034, "R1 default addr");
    set_src(32'h0, 32'h0000_0400);
    check("R1 idle irq", {31'h0, irq_o}, 32'h1);
    set_src(32'h0, 32'h0);

    // R7: identification bytes
    for (int b = 0; b < 8; b++) do_read(12'hFE0 + 12'(b * 4), "R7 id byte");

    // R2: field layout and readback
    do_write(12'h208, 32'h0000_0025);   // slot 2: enable, source 5
    do_write(12'h21C, 32'h0000_0029);   // slot 7: enable, source 9
    do_write(12'h108, 32'hA000_0002);
    do_write(12'h11C, 32'hA000_0007);
    do_write(12'h034, 32'hDEF0_0000);
    do_read(12'h208, "R2 ctrl readback");
    do_read(12'h11C, "R2 addr readback");
    do_read(12'h034, "R2 default readback");

    // R9: unmapped read zero, write discarded
    do_write(12'h0A0, 32'hFFFF_FFFF);
    do_read(12'h0A0, "R9 unmapped read");

    // R4/R5/R6: nesting
    set_src(32'h0000_0200, 32'h0000_0200);
    do_read(12'h030, "R4 ack slot7");
    set_src(32'h0000_0200, 32'h0000_0200);
    check("R3 same level blocked", {31'h0, irq_o}, 32'h0);
    do_read(12'h034, "R9 default read no side effect");
    set_src(32'h0000_0220, 32'h0000_0220);
    check("R3 higher slot fires", {31'h0, irq_o}, 32'h1);
    do_read(12'h030, "R4 ack slot2 nested");
    do_read(12'h030, "R5 no higher pending");
    do_write(12'h030, 32'h1234_5678);
    check("R6 unwind to 7", m_cur, 7);
    do_write(12'h030, 32'h0);
    do_write(12'h030, 32'h0);           // idle: no effect
    set_src(32'h0, 32'h0);
    do_read(12'h030, "R5 idle empty gives default");
    set_src(32'h8000_0000, 32'h8000_0000);
    do_read(12'h030, "R4 unclaimed to level 16");
    do_write(12'h030, 32'h0);

    // R8: mask update visible the cycle after the write
    set_src(32'h0, 32'h0000_0020);
    do_read(12'h030, "R5 read at idle");
    do_write(12'h200, 32'h0000_0023);   // slot 0 source 3

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      logic [31:0] raw;
      raw = ($urandom_range(0, 3) == 0) ? 32'h0 :
            ((32'h1 << $urandom_range(0, 31)) | (($urandom_range(0, 1) != 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0));
      case (op)
        0: do_write(12'h200 + 12'($urandom_range(0, 15) * 4), {24'h0, 8'($urandom)});
        1: do_write(12'h100 + 12'($urandom_range(0, 15) * 4), $urandom);
        2: do_write(12'h034, $urandom);
        3, 4: set_src(raw, raw & $urandom);
        5, 6: do_read(12'h030, "R4 random ack");
        7: do_write(12'h030, $urandom);
        8: do_read(12'h200 + 12'($urandom_range(0, 15) * 4), "R2 random ctrl read");
        default: do_read(12'h100 + 12'($urandom_range(0, 15) * 4), "R2 random addr read");
      endcase
    end
    finish_run();
  end
endmodule